// File: doc/BRIEF.md
# Two-Stage Serial Bit Clock Generator

This block derives the receive and transmit bit clocks for one serial channel from two external clock pins. Both pins are brought into the system clock domain by a synchronizer, and each rising edge becomes a one-cycle enable. The block therefore runs on a single clock, and every output is a one-cycle clock enable rather than a real clock.

The first stage holds two 5-bit prescalers. Each one picks a pin and divides that pin's edges by 32, 16, 8 or 4. The first prescaler always takes its ratio from its own field. The second prescaler takes its ratio either from that same field or from the phase-locked loop's divide field, depending on a select bit. The second stage holds two 16-bit down-counting baud generators. Each one takes either prescaler output or either pin as its input. Each generator reloads a time constant N, so it divides its input by N+1.

Each prescaler has the states ST_HALT (source disabled, count held at zero, ratio loaded) and ST_COUNT (counting source enables). It moves from ST_HALT to ST_COUNT when the source field selects a pin and back when it does not. Each generator has the states ST_IDLE (disabled, count preset to the time constant) and ST_RUN (decrementing). It moves from ST_IDLE to ST_RUN when its enable goes high and back when the enable goes low.

Top module: `bitclk_gen`

## Requirements
- R1: A prescaler source code of 2'b10 selects rising edges of `rx_pin`, 2'b11 selects rising edges of `tx_pin`, and 2'b00 or 2'b01 disables the prescaler.
- R2: Prescaler 0 divides its source edges by the ratio its own divide code gives: 2'b00 gives 32, 2'b01 gives 16, 2'b10 gives 8 and 2'b11 gives 4.
- R3: Prescaler 1 uses the same ratio encoding. It reads the code from `pre0_div` when `pre1_div_sel` is 0 and from `dpll_div` when it is 1.
- R4: A disabled prescaler issues no tick from the cycle after the disable is sampled, and it holds its count at zero. After reset, every tick output is low.
- R5: A generator source code of 2'b00 selects prescaler 0 ticks, 2'b01 selects prescaler 1 ticks, 2'b10 selects `rx_pin` rising edges and 2'b11 selects `tx_pin` rising edges.
- R6: A running generator with time constant N issues one tick every N+1 source enables. With N = 0 it ticks on every enable.
- R7: While a generator's enable is low, it issues no tick and holds its count at the time constant.
- R8: A load strobe reloads the time constant at once and overrides a source enable in the same cycle. No tick follows in the next cycle.
- R9: Every tick output is high for exactly one cycle at a time.
- R10: A change of a prescaler's divide code takes effect at that prescaler's next wrap. The period measured after the change equals the new ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_pin | input | 1 | Receive clock pin, asynchronous |
| tx_pin | input | 1 | Transmit clock pin, asynchronous |
| pre0_src | input | 2 | Prescaler 0 source code |
| pre1_src | input | 2 | Prescaler 1 source code |
| pre0_div | input | 2 | Prescaler 0 divide code |
| dpll_div | input | 2 | Phase-locked loop divide code, optionally used by prescaler 1 |
| pre1_div_sel | input | 1 | Selects prescaler 1's divide code source |
| gen0_src | input | 2 | Generator 0 source code |
| gen1_src | input | 2 | Generator 1 source code |
| gen0_en | input | 1 | Generator 0 run enable |
| gen1_en | input | 1 | Generator 1 run enable |
| gen0_load | input | 1 | Generator 0 reload strobe |
| gen1_load | input | 1 | Generator 1 reload strobe |
| gen0_tc | input | 16 | Generator 0 time constant |
| gen1_tc | input | 16 | Generator 1 time constant |
| pre0_tick | output | 1 | Prescaler 0 output enable |
| pre1_tick | output | 1 | Prescaler 1 output enable |
| gen0_tick | output | 1 | Generator 0 output enable |
| gen1_tick | output | 1 | Generator 1 output enable |

## Verification
A generator's reload strobe and a source enable can arrive in the same cycle. The reload must win, and no tick may be issued. The bench provokes this by holding the strobe high across many pin edges while the generator counts `rx_pin` edges, and it judges the result by seeing no tick on `gen0_tick`. It then releases the strobe and confirms that the normal N+1 period returns. A prescaler wrap and a change of its divide code can also coincide. The sweep changes codes on a running prescaler and compares each settled period with the new ratio.

// File: rtl/bclk_pkg.sv
package bclk_pkg;

    typedef enum logic [1:0] {
        PS_OFF   = 2'b00,
        PS_RSVD  = 2'b01,
        PS_RXPIN = 2'b10,
        PS_TXPIN = 2'b11
    } pre_src_e;

    typedef enum logic [1:0] {
        GS_PRE0  = 2'b00,
        GS_PRE1  = 2'b01,
        GS_RXPIN = 2'b10,
        GS_TXPIN = 2'b11
    } gen_src_e;

    // divide code to ratio: 32 >> code
    function automatic int unsigned div_ratio(input logic [1:0] code);
        return 32'd32 >> code;
    endfunction

endpackage

// File: rtl/bclk_pin_sync.sv
module bclk_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise
);
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-1:0], pin};
    end

    assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/bclk_prescaler.sv
module bclk_prescaler import bclk_pkg::*; #(
    parameter int W = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       in_en,
    input  logic [1:0] div_code,
    output logic       tick
);
    typedef enum logic {ST_HALT, ST_COUNT} pre_st_e;

    pre_st_e       state, state_nx;
    logic [W-1:0]  cnt;
    logic [W-1:0]  lim;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_HALT;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_HALT:  if (run)  state_nx = ST_COUNT;
            ST_COUNT: if (!run) state_nx = ST_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            lim  <= W'(div_ratio(2'b00) - 1);
            tick <= 1'b0;
        end else begin
            tick <= 1'b0;
            unique case (state)
                ST_HALT: begin
                    cnt <= '0;
                    lim <= W'(div_ratio(div_code) - 1);
                end
                ST_COUNT: begin
                    if (!run) begin
                        cnt <= '0;
                    end else if (in_en) begin
                        if (cnt == lim) begin
                            cnt  <= '0;
                            tick <= 1'b1;
                            lim  <= W'(div_ratio(div_code) - 1);
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/bclk_baud_gen.sv
module bclk_baud_gen #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic         load,
    input  logic         in_en,
    input  logic [W-1:0] tc,
    output logic         tick
);
    typedef enum logic {ST_IDLE, ST_RUN} gen_st_e;

    gen_st_e      state, state_nx;
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (enable)  state_nx = ST_RUN;
            ST_RUN:  if (!enable) state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else begin
            tick <= 1'b0;
            unique case (state)
                ST_IDLE: cnt <= tc;
                ST_RUN: begin
                    if (!enable || load) begin
                        cnt <= tc;
                    end else if (in_en) begin
                        if (cnt == '0) begin
                            cnt  <= tc;
                            tick <= 1'b1;
                        end else begin
                            cnt <= cnt - 1'b1;
                        end
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/bitclk_gen.sv
module bitclk_gen import bclk_pkg::*; #(
    parameter int PRE_W       = 5,
    parameter int TC_W        = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rx_pin,
    input  logic            tx_pin,
    input  logic [1:0]      pre0_src,
    input  logic [1:0]      pre1_src,
    input  logic [1:0]      pre0_div,
    input  logic [1:0]      dpll_div,
    input  logic            pre1_div_sel,
    input  logic [1:0]      gen0_src,
    input  logic [1:0]      gen1_src,
    input  logic            gen0_en,
    input  logic            gen1_en,
    input  logic            gen0_load,
    input  logic            gen1_load,
    input  logic [TC_W-1:0] gen0_tc,
    input  logic [TC_W-1:0] gen1_tc,
    output logic            pre0_tick,
    output logic            pre1_tick,
    output logic            gen0_tick,
    output logic            gen1_tick
);
    localparam int NCH = 2;

    logic rx_rise, tx_rise;

    bclk_pin_sync #(.STAGES(SYNC_STAGES)) u_rx_sync (
        .clk(clk), .rst_n(rst_n), .pin(rx_pin), .rise(rx_rise));
    bclk_pin_sync #(.STAGES(SYNC_STAGES)) u_tx_sync (
        .clk(clk), .rst_n(rst_n), .pin(tx_pin), .rise(tx_rise));

    logic [1:0]      pre_src_a [NCH];
    logic [1:0]      pre_div_a [NCH];
    logic [NCH-1:0]  pre_tick_a;
    logic [1:0]      gen_src_a [NCH];
    logic [NCH-1:0]  gen_en_a, gen_load_a, gen_in_a, gen_tick_a;
    logic [TC_W-1:0] gen_tc_a  [NCH];

    assign pre_src_a[0] = pre0_src;
    assign pre_src_a[1] = pre1_src;
    assign pre_div_a[0] = pre0_div;
    assign pre_div_a[1] = pre1_div_sel ? dpll_div : pre0_div;
    assign gen_src_a[0] = gen0_src;
    assign gen_src_a[1] = gen1_src;
    assign gen_tc_a[0]  = gen0_tc;
    assign gen_tc_a[1]  = gen1_tc;
    assign gen_en_a     = {gen1_en, gen0_en};
    assign gen_load_a   = {gen1_load, gen0_load};

    for (genvar i = 0; i < NCH; i++) begin : g_pre
        logic in_en;
        always_comb begin
            case (pre_src_e'(pre_src_a[i]))
                PS_RXPIN: in_en = rx_rise;
                PS_TXPIN: in_en = tx_rise;
                default:  in_en = 1'b0;
            endcase
        end
        bclk_prescaler #(.W(PRE_W)) u_pre (
            .clk(clk), .rst_n(rst_n), .run(pre_src_a[i][1]), .in_en(in_en),
            .div_code(pre_div_a[i]), .tick(pre_tick_a[i]));
    end

    for (genvar i = 0; i < NCH; i++) begin : g_gen
        always_comb begin
            unique case (gen_src_e'(gen_src_a[i]))
                GS_PRE0:  gen_in_a[i] = pre_tick_a[0];
                GS_PRE1:  gen_in_a[i] = pre_tick_a[1];
                GS_RXPIN: gen_in_a[i] = rx_rise;
                GS_TXPIN: gen_in_a[i] = tx_rise;
            endcase
        end
        bclk_baud_gen #(.W(TC_W)) u_gen (
            .clk(clk), .rst_n(rst_n), .enable(gen_en_a[i]), .load(gen_load_a[i]),
            .in_en(gen_in_a[i]), .tc(gen_tc_a[i]), .tick(gen_tick_a[i]));
    end

    logic gen0_in, gen1_in;
    assign gen0_in = gen_in_a[0];
    assign gen1_in = gen_in_a[1];

    assign pre0_tick = pre_tick_a[0];
    assign pre1_tick = pre_tick_a[1];
    assign gen0_tick = gen_tick_a[0];
    assign gen1_tick = gen_tick_a[1];
endmodule

// File: rtl/bitclk_gen_chk.sv
module bitclk_gen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] pre0_src,
    input logic [1:0] pre1_src,
    input logic       gen0_en,
    input logic       gen1_en,
    input logic       gen0_load,
    input logic       gen1_load,
    input logic       gen0_in,
    input logic       gen1_in,
    input logic       pre0_tick,
    input logic       pre1_tick,
    input logic       gen0_tick,
    input logic       gen1_tick
);
    p_pre0_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!pre0_src[1]) |-> !pre0_tick);
    p_pre1_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!pre1_src[1]) |-> !pre1_tick);
    p_gen0_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!gen0_en) |-> !gen0_tick);
    p_gen1_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!gen1_en) |-> !gen1_tick);
    p_gen0_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(gen0_load) |-> !gen0_tick);
    p_gen1_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(gen1_load) |-> !gen1_tick);
    p_gen0_needs_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        gen0_tick |-> $past(gen0_in));
    p_gen1_needs_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        gen1_tick |-> $past(gen1_in));
    p_pre0_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pre0_tick |=> !pre0_tick);
    p_pre1_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pre1_tick |=> !pre1_tick);
    p_gen0_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        gen0_tick |=> !gen0_tick);
    p_gen1_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        gen1_tick |=> !gen1_tick);
endmodule

bind bitclk_gen bitclk_gen_chk u_chk (
    .clk(clk), .rst_n(rst_n), .pre0_src(pre0_src), .pre1_src(pre1_src),
    .gen0_en(gen0_en), .gen1_en(gen1_en), .gen0_load(gen0_load),
    .gen1_load(gen1_load), .gen0_in(gen0_in), .gen1_in(gen1_in),
    .pre0_tick(pre0_tick), .pre1_tick(pre1_tick),
    .gen0_tick(gen0_tick), .gen1_tick(gen1_tick));

// File: tb/tb_bitclk_gen.sv
module tb_bitclk_gen;
    localparam int RX_HALF = 3;   // rx period 6 cycles
    localparam int TX_HALF = 5;   // tx period 10 cycles
    localparam int RXP = 2 * RX_HALF;
    localparam int TXP = 2 * TX_HALF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_pin = 1'b0, tx_pin = 1'b0;
    logic [1:0] pre0_src = 2'b00, pre1_src = 2'b00, pre0_div = 2'b00, dpll_div = 2'b00;
    logic pre1_div_sel = 1'b0;
    logic [1:0] gen0_src = 2'b00, gen1_src = 2'b00;
    logic gen0_en = 1'b0, gen1_en = 1'b0, gen0_load = 1'b0, gen1_load = 1'b0;
    logic [15:0] gen0_tc = '0, gen1_tc = '0;
    logic pre0_tick, pre1_tick, gen0_tick, gen1_tick;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    bitclk_gen dut (
        .clk(clk), .rst_n(rst_n), .rx_pin(rx_pin), .tx_pin(tx_pin),
        .pre0_src(pre0_src), .pre1_src(pre1_src), .pre0_div(pre0_div),
        .dpll_div(dpll_div), .pre1_div_sel(pre1_div_sel),
        .gen0_src(gen0_src), .gen1_src(gen1_src), .gen0_en(gen0_en),
        .gen1_en(gen1_en), .gen0_load(gen0_load), .gen1_load(gen1_load),
        .gen0_tc(gen0_tc), .gen1_tc(gen1_tc), .pre0_tick(pre0_tick),
        .pre1_tick(pre1_tick), .gen0_tick(gen0_tick), .gen1_tick(gen1_tick));

    initial forever begin
        repeat (RX_HALF) @(negedge clk);
        rx_pin = ~rx_pin;
    end
    initial forever begin
        repeat (TX_HALF) @(negedge clk);
        tx_pin = ~tx_pin;
    end

    typedef struct {
        int    out_id;
        int    period;
        string tag;
    } exp_t;

    exp_t sb_q[$];

    function automatic logic tick_of(input int id);
        case (id)
            0: return pre0_tick;
            1: return pre1_tick;
            2: return gen0_tick;
            default: return gen1_tick;
        endcase
    endfunction

    function automatic int ratio(input logic [1:0] code);
        return 32 >> code;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_tick(input int id, output int cyc, output bit ok);
        cyc = 0;
        ok  = 1'b0;
        while (cyc < 50000) begin
            @(negedge clk);
            cyc++;
            if (tick_of(id)) begin
                ok = 1'b1;
                break;
            end
        end
    endtask

    // monitor: pops expected periods and measures them
    initial begin
        forever begin
            int  c;
            bit  ok;
            wait (sb_q.size() > 0);
            wait_tick(sb_q[0].out_id, c, ok);
            if (ok) wait_tick(sb_q[0].out_id, c, ok);
            if (ok) wait_tick(sb_q[0].out_id, c, ok);
            if (!ok) c = -1;
            check(c == sb_q[0].period, sb_q[0].tag, c, sb_q[0].period);
            if (ok) begin
                @(negedge clk);
                check(!tick_of(sb_q[0].out_id), "R9 single-cycle tick",
                      int'(tick_of(sb_q[0].out_id)), 0);
            end
            void'(sb_q.pop_front());
        end
    end

    task automatic expect_period(input int id, input int period, input string tag);
        exp_t e;
        e.out_id = id;
        e.period = period;
        e.tag    = tag;
        sb_q.push_back(e);
        wait (sb_q.size() == 0);
        @(negedge clk);
    endtask

    task automatic expect_quiet(input int id, input int ncyc, input string tag);
        int seen = 0;
        repeat (4) @(negedge clk);
        for (int k = 0; k < ncyc; k++) begin
            @(negedge clk);
            if (tick_of(id)) seen++;
        end
        check(seen == 0, tag, seen, 0);
    endtask

    initial begin
        int rst_ticks = 0;
        repeat (5) begin
            @(negedge clk);
            rst_ticks += int'(pre0_tick) + int'(pre1_tick) + int'(gen0_tick) + int'(gen1_tick);
        end
        check(rst_ticks == 0, "R4 ticks low in reset", rst_ticks, 0);
        rst_n = 1'b1;
        expect_quiet(0, 60, "R4 prescaler 0 idle after reset");

        // R1 / R2 / R10: prescaler 0 sweep, divide code changed while running
        for (int s = 2; s <= 3; s++) begin
            pre0_src = 2'(s);
            for (int d = 0; d < 4; d++) begin
                pre0_div = 2'(d);
                expect_period(0, ratio(2'(d)) * (s == 2 ? RXP : TXP),
                              "R1 R2 R10 prescaler 0 period");
            end
        end

        // R1 / R4: disabled and reserved codes
        pre0_src = 2'b00;
        expect_quiet(0, 400, "R1 R4 prescaler 0 code 00 silent");
        pre0_src = 2'b01;
        expect_quiet(0, 400, "R1 R4 prescaler 0 code 01 silent");

        // R3: prescaler 1 divide source selection
        pre1_src = 2'b10;
        for (int d = 0; d < 4; d++) begin
            pre1_div_sel = 1'b0;
            pre0_div = 2'(d);
            dpll_div = 2'(3 - d);
            expect_period(1, ratio(2'(d)) * RXP, "R3 prescaler 1 sel=0");
            pre1_div_sel = 1'b1;
            dpll_div = 2'(d);
            pre0_div = 2'(3 - d);
            expect_period(1, ratio(2'(d)) * RXP, "R3 prescaler 1 sel=1");
        end
        pre1_src = 2'b00;
        expect_quiet(1, 300, "R4 prescaler 1 disabled");

        // R5 / R6: generator sources
        pre0_src = 2'b10; pre0_div = 2'b11;          // 24 cycles
        pre1_src = 2'b11; pre1_div_sel = 1'b0;       // 40 cycles
        gen0_tc = 16'd2; gen1_tc = 16'd4;
        gen0_en = 1'b1; gen1_en = 1'b1;
        for (int s = 0; s < 4; s++) begin
            int base;
            base = (s == 0) ? 4 * RXP : (s == 1) ? 4 * TXP : (s == 2) ? RXP : TXP;
            gen0_src = 2'(s);
            gen1_src = 2'(s);
            expect_period(2, 3 * base, "R5 R6 generator 0 source");
            expect_period(3, 5 * base, "R5 R6 generator 1 source");
        end

        // R6: time constant zero and large
        gen0_src = 2'b10;
        gen0_tc = 16'd0;
        expect_period(2, RXP, "R6 tc=0 every enable");
        gen0_tc = 16'd1000;
        gen0_load = 1'b1; @(negedge clk); gen0_load = 1'b0;
        expect_period(2, 1001 * RXP, "R6 tc=1000");

        // R8: load strobe held across source enables suppresses ticks
        gen0_tc = 16'd2;
        gen0_load = 1'b1;
        expect_quiet(2, 120, "R8 load overrides enables");
        gen1_src = 2'b10;
        expect_period(3, 5 * RXP, "R8 other generator unaffected");
        gen0_load = 1'b0;
        expect_period(2, 3 * RXP, "R8 period after release");

        // R7: generator disable
        gen0_en = 1'b0;
        expect_quiet(2, 200, "R7 generator 0 disabled");
        gen1_en = 1'b0;
        expect_quiet(3, 200, "R7 generator 1 disabled");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule